// File: doc/BRIEF.md
# Indirect SERDES Control-Register Access Engine

This block is a bus master that carries out one read or one write of a SERDES control register at a time. The control-register space cannot be reached directly. It is seen through a 512-word window on a simple synchronous register bus. A select register at bus offset 0x800 picks which page of which PHY device the window shows. Inside that space, three fixed handshake registers (control, address, data) carry the real transfer. The engine turns one request into the whole sequence of bus cycles: select writes, window accesses and busy polls.

A requester presents a device number, a 16-bit target register address, write data and a write flag while `req_ready` is high. The engine then works through the sequence alone and ends with a single-cycle `done`. With `done` it returns read data or, if the busy flag never cleared within the allowed number of polls, a `timeout` flag. The bus has one cycle of read latency: data for a read strobe is valid in the following cycle. Busy is polled once per `POLL_GAP` clock cycles. The default of 250 gives 5 µs at 50 MHz.

Top module: `phycr_access`

## Requirements
- R1: After reset `req_ready` is 1, and `done`, `timeout`, `bus_wr` and `bus_rd` are 0.
- R2: Every window access (any bus strobe whose offset is not 0x800) comes in the cycle right after a bus write to offset 0x800. That write carries the latched device number in bits 11:7 and bits 15:9 of the register being accessed in bits 6:0. For the handshake registers those bits are 0x40.
- R3: A window access uses bus offset equal to the register address bits 8:0 shifted left by 2. Control (0x80A0) is at 0x280, address (0x80A1) at 0x284 and data (0x80A2) at 0x288.
- R4: A read runs in this order: poll control, write the address register with the target address, write control with 0x1 (start), poll control, read the data register. Bits of the data-register read that fit the data width are returned on `rdata` with `done`.
- R5: A write runs in this order: poll control, write the address register, write the data register, write control with 0x3 (start plus write). `done` follows with no further poll.
- R6: Bit 0 of a control read is busy. While it reads 1, control is read again with bus strobes spaced exactly `POLL_GAP`+3 cycles apart, and the sequence does not move on.
- R7: If busy is read as 1 `POLL_LIMIT` times in one poll phase, the transaction ends with `done` and `timeout` both 1 and `rdata` 0, and no further bus access. The count restarts for the second poll phase of a read.
- R8: `req_ready` falls on acceptance and rises with `done`. Requests presented while it is low are ignored, and the bus stays idle while it is high.
- R9: `done` is a one-cycle pulse, and `timeout` is only ever high together with `done`.
- R10: `bus_wr` and `bus_rd` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request taken when valid |
| req_dev | input | DEV_W | PHY device number |
| req_addr | input | ADDR_W | Target SERDES register address |
| req_wdata | input | DATA_W | Write data |
| req_write | input | 1 | 1 = write, 0 = read |
| done | output | 1 | Transaction finished (one cycle) |
| rdata | output | DATA_W | Read result, valid with done |
| timeout | output | 1 | Busy poll limit reached, valid with done |
| bus_wr | output | 1 | Register bus write strobe |
| bus_rd | output | 1 | Register bus read strobe |
| bus_offset | output | OFS_W | Register bus byte offset |
| bus_wdata | output | BUS_W | Register bus write data |
| bus_rdata | input | BUS_W | Register bus read data, one cycle after bus_rd |

## Verification
Several rules are checked by the assertions on every cycle. Each window access must come right after a select write that names the accepted device and the handshake page. Offsets must stay within the three handshake registers. `done` must be a pulse, with `timeout` only alongside it, and the bus must be quiet whenever the engine is ready. Other properties need a behavioural PHY register file behind the bus, so only the bench scenarios show them. These are the exact order of handshake accesses and control values for reads and writes, the data carried through the window, the poll spacing, the per-phase poll limit and the absence of a completion wait after a write.

// File: rtl/phycr_pkg.sv
package phycr_pkg;
  // handshake register addresses inside the SERDES control space
  localparam logic [15:0] HS_CTL = 16'h80A0;
  localparam logic [15:0] HS_ADR = 16'h80A1;
  localparam logic [15:0] HS_DAT = 16'h80A2;
  // window select register and window geometry
  localparam logic [11:0] SEL_OFS   = 12'h800;
  localparam int          WIN_IDX_W = 9;
  // control register write values
  localparam logic [1:0]  KICK_RD   = 2'b01;
  localparam logic [1:0]  KICK_WR   = 2'b11;

  typedef enum logic [2:0] {
    ST_POLL_IN, ST_PUT_ADDR, ST_PUT_DATA, ST_KICK, ST_POLL_OUT, ST_GET_DATA
  } step_t;

  typedef enum logic [2:0] {
    PH_IDLE, PH_SEL, PH_ACC, PH_RWAIT, PH_GAP
  } phase_t;
endpackage

// File: rtl/phycr_winfmt.sv
module phycr_winfmt
  import phycr_pkg::*;
#(
  parameter int DEV_W  = 5,
  parameter int ADDR_W = 16,
  parameter int BUS_W  = 32,
  parameter int OFS_W  = 12
) (
  input  logic [DEV_W-1:0]  dev,
  input  logic [ADDR_W-1:0] reg_addr,
  output logic [BUS_W-1:0]  sel_word,
  output logic [OFS_W-1:0]  win_ofs
);
  localparam int PAGE_W = ADDR_W - WIN_IDX_W;

  // device above page, zero extended to the bus width
  assign sel_word = BUS_W'({dev, reg_addr[ADDR_W-1 -: PAGE_W]});
  // 32-bit word spacing inside the window
  assign win_ofs  = OFS_W'({reg_addr[WIN_IDX_W-1:0], 2'b00});
endmodule

// File: rtl/phycr_pace.sv
module phycr_pace #(
  parameter int POLL_GAP   = 250,
  parameter int POLL_LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,        // busy seen, start an interval
  input  logic tries_clr,  // new poll phase
  output logic gap_done,
  output logic last_try
);
  localparam int GAP_W = $clog2(POLL_GAP + 1);
  localparam int CNT_W = $clog2(POLL_LIMIT + 1);

  logic [GAP_W-1:0] gap_cnt;
  logic             gap_on;
  logic [CNT_W-1:0] tries;

  assign gap_done = gap_on && (gap_cnt == '0);
  assign last_try = (tries == CNT_W'(POLL_LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_cnt <= '0;
      gap_on  <= 1'b0;
    end else if (arm) begin
      gap_cnt <= GAP_W'(POLL_GAP - 1);
      gap_on  <= 1'b1;
    end else if (gap_done) begin
      gap_on  <= 1'b0;
    end else if (gap_on) begin
      gap_cnt <= gap_cnt - GAP_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || tries_clr) tries <= '0;
    else if (arm)         tries <= tries + CNT_W'(1);
  end
endmodule

// File: rtl/phycr_seq.sv
module phycr_seq
  import phycr_pkg::*;
#(
  parameter int DEV_W  = 5,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int BUS_W  = 32,
  parameter int OFS_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [DEV_W-1:0]  req_dev,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_write,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              timeout,
  output logic              bus_wr,
  output logic              bus_rd,
  output logic [OFS_W-1:0]  bus_offset,
  output logic [BUS_W-1:0]  bus_wdata,
  input  logic [DATA_W-1:0] rd_word,
  output logic [DEV_W-1:0]  win_dev,
  output logic [ADDR_W-1:0] win_reg,
  input  logic [BUS_W-1:0]  sel_word,
  input  logic [OFS_W-1:0]  win_ofs,
  input  logic              gap_done,
  input  logic              last_try,
  output logic              arm,
  output logic              tries_clr
);
  phase_t            phase;
  step_t             step;
  logic [DEV_W-1:0]  r_dev;
  logic [ADDR_W-1:0] r_addr;
  logic [DATA_W-1:0] r_wdata;
  logic              r_write;
  logic              step_rd, step_poll, busy_seen, accept;
  logic [BUS_W-1:0]  acc_data;

  assign step_poll = (step == ST_POLL_IN) || (step == ST_POLL_OUT);
  assign step_rd   = step_poll || (step == ST_GET_DATA);
  assign busy_seen = rd_word[0];
  assign accept    = req_valid && req_ready;
  assign win_dev   = r_dev;

  always_comb begin
    case (step)
      ST_PUT_ADDR:              win_reg = ADDR_W'(HS_ADR);
      ST_PUT_DATA, ST_GET_DATA: win_reg = ADDR_W'(HS_DAT);
      default:                  win_reg = ADDR_W'(HS_CTL);
    endcase
    case (step)
      ST_PUT_ADDR: acc_data = BUS_W'(r_addr);
      ST_PUT_DATA: acc_data = BUS_W'(r_wdata);
      ST_KICK:     acc_data = r_write ? BUS_W'(KICK_WR) : BUS_W'(KICK_RD);
      default:     acc_data = '0;
    endcase
  end

  // bus strobes decoded from registered phase and step
  assign bus_wr     = (phase == PH_SEL) || ((phase == PH_ACC) && !step_rd);
  assign bus_rd     = (phase == PH_ACC) && step_rd;
  assign bus_offset = (phase == PH_SEL) ? OFS_W'(SEL_OFS) :
                      (phase == PH_ACC) ? win_ofs : '0;
  assign bus_wdata  = (phase == PH_SEL) ? sel_word :
                      (phase == PH_ACC) ? acc_data : '0;

  assign arm       = (phase == PH_RWAIT) && step_poll && busy_seen && !last_try;
  assign tries_clr = accept || ((phase == PH_ACC) && (step == ST_KICK));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      step      <= ST_POLL_IN;
      req_ready <= 1'b1;
      done      <= 1'b0;
      timeout   <= 1'b0;
      rdata     <= '0;
      r_dev     <= '0;
      r_addr    <= '0;
      r_wdata   <= '0;
      r_write   <= 1'b0;
    end else begin
      done    <= 1'b0;
      timeout <= 1'b0;
      case (phase)
        PH_IDLE: if (accept) begin
          r_dev     <= req_dev;
          r_addr    <= req_addr;
          r_wdata   <= req_wdata;
          r_write   <= req_write;
          rdata     <= '0;
          step      <= ST_POLL_IN;
          phase     <= PH_SEL;
          req_ready <= 1'b0;
        end
        PH_SEL: phase <= PH_ACC;
        PH_ACC: begin
          phase <= step_rd ? PH_RWAIT : PH_SEL;
          case (step)
            ST_PUT_ADDR: step <= r_write ? ST_PUT_DATA : ST_KICK;
            ST_PUT_DATA: step <= ST_KICK;
            ST_KICK: begin
              if (r_write) begin
                phase     <= PH_IDLE;
                done      <= 1'b1;
                req_ready <= 1'b1;
              end else begin
                step <= ST_POLL_OUT;
              end
            end
            default: ;
          endcase
        end
        PH_RWAIT: begin
          if (step == ST_GET_DATA) begin
            rdata     <= rd_word;
            phase     <= PH_IDLE;
            done      <= 1'b1;
            req_ready <= 1'b1;
          end else if (busy_seen) begin
            if (last_try) begin
              timeout   <= 1'b1;
              phase     <= PH_IDLE;
              done      <= 1'b1;
              req_ready <= 1'b1;
            end else begin
              phase <= PH_GAP;
            end
          end else begin
            step  <= (step == ST_POLL_IN) ? ST_PUT_ADDR : ST_GET_DATA;
            phase <= PH_SEL;
          end
        end
        PH_GAP: if (gap_done) phase <= PH_SEL;
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/phycr_access.sv
module phycr_access #(
  parameter int DEV_W      = 5,
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 16,
  parameter int BUS_W      = 32,
  parameter int OFS_W      = 12,
  parameter int POLL_GAP   = 250,
  parameter int POLL_LIMIT = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [DEV_W-1:0]  req_dev,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_write,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              timeout,
  output logic              bus_wr,
  output logic              bus_rd,
  output logic [OFS_W-1:0]  bus_offset,
  output logic [BUS_W-1:0]  bus_wdata,
  input  logic [BUS_W-1:0]  bus_rdata
);
  logic [DEV_W-1:0]  win_dev;
  logic [ADDR_W-1:0] win_reg;
  logic [BUS_W-1:0]  sel_word;
  logic [OFS_W-1:0]  win_ofs;
  logic              gap_done, last_try, arm, tries_clr;
  logic              rdata_hi_unused;

  assign rdata_hi_unused = ^bus_rdata[BUS_W-1:DATA_W];

  phycr_winfmt #(.DEV_W(DEV_W), .ADDR_W(ADDR_W), .BUS_W(BUS_W), .OFS_W(OFS_W)) u_fmt (
    .dev(win_dev), .reg_addr(win_reg), .sel_word(sel_word), .win_ofs(win_ofs)
  );

  phycr_pace #(.POLL_GAP(POLL_GAP), .POLL_LIMIT(POLL_LIMIT)) u_pace (
    .clk(clk), .rst(rst), .arm(arm), .tries_clr(tries_clr),
    .gap_done(gap_done), .last_try(last_try)
  );

  phycr_seq #(.DEV_W(DEV_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUS_W(BUS_W),
              .OFS_W(OFS_W)) u_seq (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_dev(req_dev),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_write(req_write),
    .done(done), .rdata(rdata), .timeout(timeout),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_offset(bus_offset), .bus_wdata(bus_wdata),
    .rd_word(bus_rdata[DATA_W-1:0]),
    .win_dev(win_dev), .win_reg(win_reg), .sel_word(sel_word), .win_ofs(win_ofs),
    .gap_done(gap_done), .last_try(last_try), .arm(arm), .tries_clr(tries_clr)
  );
endmodule

// File: rtl/phycr_access_chk.sv
module phycr_access_chk
  import phycr_pkg::*;
#(
  parameter int DEV_W  = 5,
  parameter int ADDR_W = 16,
  parameter int BUS_W  = 32,
  parameter int OFS_W  = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic [DEV_W-1:0] req_dev,
  input logic             done,
  input logic             timeout,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic [OFS_W-1:0] bus_offset,
  input logic [BUS_W-1:0] bus_wdata
);
  localparam int PAGE_W = ADDR_W - WIN_IDX_W;
  localparam logic [OFS_W-1:0] O_SEL = OFS_W'(SEL_OFS);
  localparam logic [OFS_W-1:0] O_CTL = OFS_W'({HS_CTL[WIN_IDX_W-1:0], 2'b00});
  localparam logic [OFS_W-1:0] O_ADR = OFS_W'({HS_ADR[WIN_IDX_W-1:0], 2'b00});
  localparam logic [OFS_W-1:0] O_DAT = OFS_W'({HS_DAT[WIN_IDX_W-1:0], 2'b00});

  logic [DEV_W-1:0] cap_dev;
  logic             sel_wr, win_acc, wdata_unused;

  assign sel_wr       = bus_wr && (bus_offset == O_SEL);
  assign win_acc      = (bus_wr || bus_rd) && (bus_offset != O_SEL);
  assign wdata_unused = ^bus_wdata;

  always_ff @(posedge clk) begin
    if (rst) cap_dev <= '0;
    else if (req_valid && req_ready) cap_dev <= req_dev;
  end

  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (req_ready && !done && !timeout && !bus_wr && !bus_rd));

  a_r2_sel_first: assert property (@(posedge clk) disable iff (rst)
    win_acc |-> $past(sel_wr));

  a_r2_sel_dev: assert property (@(posedge clk) disable iff (rst)
    sel_wr |-> (bus_wdata[PAGE_W+DEV_W-1:PAGE_W] == cap_dev));

  a_r2_sel_page: assert property (@(posedge clk) disable iff (rst)
    sel_wr |-> (bus_wdata[PAGE_W-1:0] == HS_CTL[ADDR_W-1:WIN_IDX_W]));

  a_r3_win_offset: assert property (@(posedge clk) disable iff (rst)
    win_acc |-> (bus_offset == O_CTL || bus_offset == O_ADR || bus_offset == O_DAT));

  a_r8_accept_drop: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (!bus_wr && !bus_rd));

  a_r8_done_ready: assert property (@(posedge clk) disable iff (rst)
    done |-> req_ready);

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r9_timeout_with_done: assert property (@(posedge clk) disable iff (rst)
    timeout |-> done);

  a_r10_one_strobe: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_rd));
endmodule

bind phycr_access phycr_access_chk #(
  .DEV_W(DEV_W), .ADDR_W(ADDR_W), .BUS_W(BUS_W), .OFS_W(OFS_W)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_dev(req_dev), .done(done), .timeout(timeout), .bus_wr(bus_wr),
  .bus_rd(bus_rd), .bus_offset(bus_offset), .bus_wdata(bus_wdata)
);

// File: tb/phycr_access_bench.sv
module phycr_access_bench;
  localparam int GAP = 6;
  localparam int LIM = 4;

  typedef struct packed {
    logic        wr;
    logic [4:0]  dev;
    logic [15:0] addr;
    logic [15:0] data;
    logic [3:0]  bp;
    logic [3:0]  bq;
  } vec_t;

  localparam vec_t VEC [0:7] = '{
    '{1'b1, 5'd3,  16'h2005, 16'h1234, 4'd0, 4'd0},
    '{1'b0, 5'd3,  16'h2005, 16'h0000, 4'd0, 4'd2},
    '{1'b0, 5'd17, 16'h0010, 16'h0000, 4'd1, 4'd0},
    '{1'b1, 5'd31, 16'h210A, 16'hBEEF, 4'd2, 4'd1},
    '{1'b0, 5'd0,  16'h210A, 16'h0000, 4'd0, 4'd3},
    '{1'b1, 5'd9,  16'hFFFF, 16'h0F0F, 4'd3, 4'd0},
    '{1'b0, 5'd9,  16'h003F, 16'h0000, 4'd0, 4'd0},
    '{1'b0, 5'd22, 16'h0001, 16'h0000, 4'd1, 4'd1}
  };

  logic        clk = 1'b0, rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [4:0]  req_dev = '0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic        req_ready, done, timeout, bus_wr, bus_rd;
  logic [15:0] rdata;
  logic [11:0] bus_offset;
  logic [31:0] bus_wdata, bus_rdata;

  int nchk = 0, nerr = 0;
  logic [15:0] exp_mem [64];

  // stimulus-side configuration for the PHY model
  logic cfg_load = 1'b0;
  int   cfg_busy_pre = 0, cfg_busy_post = 0;

  always #10 clk = ~clk;

  phycr_access #(.POLL_GAP(GAP), .POLL_LIMIT(LIM)) u_phycr_access (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_dev(req_dev), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_write(req_write), .done(done), .rdata(rdata), .timeout(timeout),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_offset(bus_offset),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  // ---------------- behavioural PHY register file behind the window -------
  logic [31:0] sel_q;
  bit          fresh, last_busy;
  int          busy, ctl_reads, events, sel_err, bad_acc, gap_err, cyc, last_poll;
  logic [15:0] addr_q, data_q;
  logic [15:0] mem [64];
  logic [63:0] sig;
  logic [4:0]  dev_seen;
  logic [15:0] full;

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (rst) begin
      sel_q = '0; fresh = 0; last_busy = 0; busy = 0; ctl_reads = 0; events = 0;
      sel_err = 0; bad_acc = 0; gap_err = 0; last_poll = 0; addr_q = '0;
      data_q = '0; sig = '0; dev_seen = '0;
      for (int i = 0; i < 64; i++) mem[i] = 16'hA500 ^ (16'(i) * 16'h0101);
      bus_rdata <= '0;
    end else begin
      if (cfg_load) begin
        busy = cfg_busy_pre; sig = '0; ctl_reads = 0; events = 0;
      end
      if (bus_wr && bus_offset == 12'h800) begin
        sel_q = bus_wdata; fresh = 1; events = events + 1;
      end else if (bus_wr || bus_rd) begin
        events = events + 1;
        if (!fresh || bus_offset[11] || bus_offset[1:0] != 2'b00) sel_err = sel_err + 1;
        fresh = 0;
        dev_seen = sel_q[11:7];
        full = {sel_q[6:0], bus_offset[10:2]};
        if (full == 16'h80A0 && bus_rd) begin
          if (last_busy && (cyc - last_poll) != GAP + 3) gap_err = gap_err + 1;
          last_poll = cyc; last_busy = (busy != 0);
          bus_rdata <= {31'd0, busy != 0};
          if (busy > 0) busy = busy - 1;
          ctl_reads = ctl_reads + 1; sig = {sig[59:0], 4'h1};
        end else if (full == 16'h80A0) begin
          last_busy = 0;
          sig = {sig[59:0], (bus_wdata[1:0] == 2'b11) ? 4'h6 :
                            (bus_wdata[1:0] == 2'b01) ? 4'h4 : 4'h7};
          if (bus_wdata[0]) begin
            if (bus_wdata[1]) mem[addr_q[5:0]] = data_q;
            else              data_q = mem[addr_q[5:0]];
            busy = cfg_busy_post;
          end
        end else if (full == 16'h80A1 && bus_wr) begin
          addr_q = bus_wdata[15:0]; sig = {sig[59:0], 4'h2};
        end else if (full == 16'h80A2 && bus_wr) begin
          data_q = bus_wdata[15:0]; sig = {sig[59:0], 4'h3};
        end else if (full == 16'h80A2) begin
          bus_rdata <= {16'd0, data_q}; sig = {sig[59:0], 4'h5};
        end else begin
          bad_acc = bad_acc + 1;
        end
      end else begin
        fresh = 0;
      end
    end
  end

  // ---------------- checking helpers -------------------------------------
  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_sig(input bit wr, input int bp, input int bq);
    logic [63:0] s = '0;
    for (int k = 0; k <= bp; k++) s = {s[59:0], 4'h1};
    s = {s[59:0], 4'h2};
    if (wr) begin
      s = {s[59:0], 4'h3}; s = {s[59:0], 4'h6};
    end else begin
      s = {s[59:0], 4'h4};
      for (int k = 0; k <= bq; k++) s = {s[59:0], 4'h1};
      s = {s[59:0], 4'h5};
    end
    return s;
  endfunction

  task automatic start_req(input bit wr, input logic [4:0] dev, input logic [15:0] a,
                           input logic [15:0] d, input int bp, input int bq);
    @(negedge clk);
    cfg_busy_pre = bp; cfg_busy_post = bq; cfg_load = 1'b1;
    req_valid = 1'b1; req_write = wr; req_dev = dev; req_addr = a; req_wdata = d;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic wait_done(output int ready_hi);
    int n = 0;
    ready_hi = 0;
    while (!done && n < 3000) begin
      if (req_ready) ready_hi++;
      @(negedge clk);
      n++;
    end
    if (!done) chk("R8 done within limit", 0, 1);
  endtask

  task automatic run_txn(input bit wr, input logic [4:0] dev, input logic [15:0] a,
                         input logic [15:0] d, input int bp, input int bq);
    int rh;
    start_req(wr, dev, a, d, bp, bq);
    req_valid = 1'b0;
    wait_done(rh);
    chk("R9 timeout clear", timeout, 0);
    chk("R2 device in select", dev_seen, dev);
    chk("R3 window offsets and select order", sel_err + bad_acc, 0);
    if (wr) begin
      chk("R5 write sequence", sig, exp_sig(1, bp, 0));
      chk("R5 no completion wait", ctl_reads, bp + 1);
      exp_mem[a[5:0]] = d;
    end else begin
      chk("R4 read sequence", sig, exp_sig(0, bp, bq));
      chk("R4 read data", rdata, exp_mem[a[5:0]]);
      chk("R6 poll count", ctl_reads, bp + bq + 2);
    end
    chk("R6 poll spacing", gap_err, 0);
  endtask

  // ---------------- watchdog ---------------------------------------------
  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  // ---------------- main sequence -----------------------------------------
  initial begin
    int rh, ev0;
    for (int i = 0; i < 64; i++) exp_mem[i] = 16'hA500 ^ (16'(i) * 16'h0101);
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready", req_ready, 1);
    chk("R1 done", done, 0);
    chk("R1 timeout", timeout, 0);
    chk("R1 bus idle", {bus_wr, bus_rd}, 0);
    chk("R10 strobes idle", bus_wr & bus_rd, 0);

    // table walk: reads and writes with varied busy counts
    for (int i = 0; i < 8; i++)
      run_txn(VEC[i].wr, VEC[i].dev, VEC[i].addr, VEC[i].data,
              int'(VEC[i].bp), int'(VEC[i].bq));

    // R7 limit counts per phase: LIM-1 busy reads in each phase is fine
    run_txn(1'b0, 5'd12, 16'h0005, 16'h0, LIM - 1, LIM - 1);

    // R7 timeout on first phase
    start_req(1'b0, 5'd4, 16'h0002, 16'h0, 9, 0);
    req_valid = 1'b0;
    wait_done(rh);
    chk("R7 timeout flag", timeout, 1);
    chk("R7 rdata zero", rdata, 0);
    chk("R7 busy reads at limit", ctl_reads, LIM);
    chk("R7 only polls issued", sig, 64'h1111);
    ev0 = events;
    repeat (20) @(negedge clk);
    chk("R7 bus silent after timeout", events, ev0);

    // R8 requests while busy are ignored; R9 done pulse width
    start_req(1'b0, 5'd7, 16'h000C, 16'h0, 0, 2);
    req_dev = 5'd30; req_addr = 16'h0001;   // valid stays high
    chk("R8 ready low after accept", req_ready, 0);
    wait_done(rh);
    req_valid = 1'b0;
    chk("R8 ready never high mid-transaction", rh, 0);
    chk("R8 ready with done", req_ready, 1);
    chk("R8 original device kept", dev_seen, 7);
    chk("R4 read data under held request", rdata, exp_mem[12]);
    ev0 = events;
    @(negedge clk);
    chk("R9 done single cycle", done, 0);
    repeat (6) @(negedge clk);
    chk("R8 no second transaction", events, ev0);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule